// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block sits in the datapath between a FIFO's storage and one of its ports. It lets the writer and the reader use different word widths. A 36-bit word can be broken into two 18-bit or four 9-bit sub-words. In the other direction, two 18-bit or four 9-bit sub-words are gathered into one 36-bit word. A straight 36-to-36 path is also available. Both sides use a valid/ready stream, and the block runs on a single clock.

Three width-select inputs choose the width pairing. A fourth input chooses the sub-word order: most significant first, or least significant first. All four inputs are captured on every clock edge while the synchronous reset `rst_n` is held low. They are frozen once reset is released.

Narrow data always travels in the low bits of the 36-bit data buses. Narrow output words are zero-padded above their width. Bits above the width on a narrow input are ignored.

Top module: `bus_width_adapter`

## Requirements
- R1: The inputs {cfg_match, cfg_in_narrow, cfg_out_narrow} select the mode, with 1 = high:
  - 000: 36-bit in, 36-bit out.
  - 100: 36-bit in, two 18-bit out.
  - 101: 36-bit in, four 9-bit out.
  - 110: two 18-bit in, 36-bit out.
  - 111: four 9-bit in, 36-bit out.
- R2: Every other combination (001, 010, 011) behaves as the 36-bit in, 36-bit out path.
- R3: The mode inputs and cfg_big_end are sampled only on clock edges where rst_n is low. Changing them after reset has no effect on the output stream.
- R4: When splitting with cfg_big_end=1, sub-words leave in order from the most significant down.
  - For 9-bit sub-words the order is bits [35:27], [26:18], [17:9], [8:0].
  - For 18-bit sub-words the order is [35:18], then [17:0].
- R5: When splitting with cfg_big_end=0, sub-words leave from the least significant up: [8:0] first, or [17:0] first.
- R6: When packing with cfg_big_end=1, the first sub-word accepted lands in the most significant position of the 36-bit word.
- R7: When packing with cfg_big_end=0, the first sub-word accepted lands in the least significant position.
- R8: A packed word is not offered (out_valid stays low) until all of its sub-words have been accepted.
- R9: While out_valid is high and out_ready is low, out_data and the current sub-word position hold unchanged.
- R10: Narrow output sub-words appear in out_data's low bits with all higher bits zero. Bits of in_data above the input width are ignored.
- R11: After a reset, out_valid is 0 and in_ready is 1.
- R12: Output data follows an accepted input by one register stage.
  - When splitting or passing through, the next 36-bit word is accepted in the same cycle that the last sub-word of the previous one is taken.
  - When packing, a new sub-word is accepted while a finished word is pending only if that word is taken in the same cycle.
  - Every sub-word is delivered exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_match | input | 1 | Selects asymmetric widths when high |
| cfg_in_narrow | input | 1 | High: input side is the narrow side |
| cfg_out_narrow | input | 1 | Narrow side is 9 bits when high, 18 bits when low |
| cfg_big_end | input | 1 | 1: most significant sub-word first; 0: least significant first |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_data | input | 36 | Input word; narrow words in the low bits |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | 36 | Output word; narrow words in the low bits, zero above |

## Verification
The bench targets the following corner cases:
- **Sub-word order in each endianness.** A converter with the order reversed would emit or pack lanes mirrored.
- **Last-lane handoff.** Here a new wide word must be taken in the same cycle as the final sub-word. Getting this wrong either drops throughput or overwrites a word still being emitted.
- **Partially packed words.** These must never surface; an early out_valid would deliver a word with stale lanes.
- **Long output stalls.** Under these a drifting lane index would skip or repeat sub-words.
- **Mode pins toggled after reset.** Unlisted pin codes must fall back to a straight path, and junk in the upper input bits must not leak into packed lanes.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

   typedef enum logic [2:0] {
      BWA_PASS   = 3'd0,
      BWA_SPLIT2 = 3'd1,
      BWA_SPLIT4 = 3'd2,
      BWA_PACK2  = 3'd3,
      BWA_PACK4  = 3'd4
   } bwa_mode_e;

   function automatic bwa_mode_e bwa_decode(input logic match, input logic in_n,
                                            input logic out_n);
      case ({match, in_n, out_n})
         3'b100:  return BWA_SPLIT2;
         3'b101:  return BWA_SPLIT4;
         3'b110:  return BWA_PACK2;
         3'b111:  return BWA_PACK4;
         default: return BWA_PASS;
      endcase
   endfunction

   function automatic logic [2:0] bwa_subwords(input bwa_mode_e m);
      case (m)
         BWA_SPLIT2, BWA_PACK2: return 3'd2;
         BWA_SPLIT4, BWA_PACK4: return 3'd4;
         default:               return 3'd1;
      endcase
   endfunction

   function automatic logic bwa_is_pack(input bwa_mode_e m);
      return (m == BWA_PACK2) || (m == BWA_PACK4);
   endfunction

endpackage

// File: rtl/bwa_cfg_latch.sv
module bwa_cfg_latch
   import bwa_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_match,
   input  logic      cfg_in_narrow,
   input  logic      cfg_out_narrow,
   input  logic      cfg_big_end,
   output bwa_mode_e mode_q,
   output logic      big_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= bwa_decode(cfg_match, cfg_in_narrow, cfg_out_narrow);
         big_q  <= cfg_big_end;
      end
   end

endmodule

// File: rtl/bwa_splitter.sv
module bwa_splitter #(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(LANES):0]   n_sub,
   input  logic                     big,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [LANE_W*LANES-1:0]  in_data,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [LANE_W*LANES-1:0]  out_data
);

   localparam int WORD_W = LANE_W * LANES;
   localparam int HALF_W = WORD_W / 2;
   localparam int IDX_W  = $clog2(LANES);

   logic [WORD_W-1:0] hold_q;
   logic              full_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_idx;
   logic [IDX_W-1:0]  slot;
   logic              at_last;
   logic [LANE_W-1:0] lane [LANES];

   assign last_idx  = IDX_W'(n_sub - 1'b1);
   assign at_last   = (idx_q == last_idx);
   assign slot      = big ? (last_idx - idx_q) : idx_q;
   assign in_ready  = !full_q || (out_ready && at_last);
   assign out_valid = full_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = hold_q[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         idx_q  <= '0;
      end else if (in_valid && in_ready) begin
         hold_q <= in_data;
         full_q <= 1'b1;
         idx_q  <= '0;
      end else if (full_q && out_ready) begin
         if (at_last) full_q <= 1'b0;
         else         idx_q  <= idx_q + 1'b1;
      end
   end

   always_comb begin
      out_data = '0;
      case (n_sub)
         (IDX_W+1)'(2): out_data[HALF_W-1:0] = slot[0] ? hold_q[WORD_W-1:HALF_W]
                                                        : hold_q[HALF_W-1:0];
         (IDX_W+1)'(LANES): out_data[LANE_W-1:0] = lane[slot];
         default: out_data = hold_q;
      endcase
   end

endmodule

// File: rtl/bwa_packer.sv
module bwa_packer #(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(LANES):0]   n_sub,
   input  logic                     big,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [LANE_W*LANES-1:0]  in_data,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [LANE_W*LANES-1:0]  out_data
);

   localparam int WORD_W = LANE_W * LANES;
   localparam int IDX_W  = $clog2(LANES);

   logic [WORD_W-1:0] acc_q;
   logic              full_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_idx;
   logic [IDX_W-1:0]  slot;
   logic              at_last;
   logic              take;
   logic              quad;

   assign last_idx  = IDX_W'(n_sub - 1'b1);
   assign at_last   = (idx_q == last_idx);
   assign slot      = big ? (last_idx - idx_q) : idx_q;
   assign quad      = (n_sub == (IDX_W+1)'(LANES));
   assign in_ready  = !full_q || out_ready;
   assign take      = in_valid && in_ready;
   assign out_valid = full_q;
   assign out_data  = acc_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic              we;
      logic [LANE_W-1:0] src;
      assign we  = take && (quad ? (slot == IDX_W'(g)) : (slot == IDX_W'(g / 2)));
      assign src = quad ? in_data[LANE_W-1:0] : in_data[(g % 2)*LANE_W +: LANE_W];
      always_ff @(posedge clk) begin
         if (we) acc_q[g*LANE_W +: LANE_W] <= src;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         if (full_q && out_ready) full_q <= 1'b0;
         if (take) begin
            if (at_last) begin
               full_q <= 1'b1;
               idx_q  <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
   import bwa_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_match,
   input  logic                    cfg_in_narrow,
   input  logic                    cfg_out_narrow,
   input  logic                    cfg_big_end,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANE_W*LANES-1:0] in_data,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [LANE_W*LANES-1:0] out_data
);

   localparam int WORD_W = LANE_W * LANES;
   localparam int IDX_W  = $clog2(LANES);

   if (LANES != 4) begin : g_bad_lanes
      $error("bus_width_adapter: mode table needs exactly four lanes");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("bus_width_adapter: LANE_W must be positive");
   end

   bwa_mode_e        mode_q;
   logic             big_q;
   logic [IDX_W:0]   n_sub;
   logic             packing;

   logic             sp_in_ready, sp_out_valid;
   logic [WORD_W-1:0] sp_out_data;
   logic             pk_in_ready, pk_out_valid;
   logic [WORD_W-1:0] pk_out_data;

   bwa_cfg_latch u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_match      (cfg_match),
      .cfg_in_narrow  (cfg_in_narrow),
      .cfg_out_narrow (cfg_out_narrow),
      .cfg_big_end    (cfg_big_end),
      .mode_q         (mode_q),
      .big_q          (big_q)
   );

   assign n_sub   = (IDX_W+1)'(bwa_subwords(mode_q));
   assign packing = bwa_is_pack(mode_q);

   bwa_splitter #(.LANE_W(LANE_W), .LANES(LANES)) u_split (
      .clk       (clk),
      .rst_n     (rst_n),
      .n_sub     (n_sub),
      .big       (big_q),
      .in_valid  (in_valid && !packing),
      .in_ready  (sp_in_ready),
      .in_data   (in_data),
      .out_valid (sp_out_valid),
      .out_ready (out_ready && !packing),
      .out_data  (sp_out_data)
   );

   bwa_packer #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .n_sub     (n_sub),
      .big       (big_q),
      .in_valid  (in_valid && packing),
      .in_ready  (pk_in_ready),
      .in_data   (in_data),
      .out_valid (pk_out_valid),
      .out_ready (out_ready && packing),
      .out_data  (pk_out_data)
   );

   assign in_ready  = packing ? pk_in_ready  : sp_in_ready;
   assign out_valid = packing ? pk_out_valid : sp_out_valid;
   assign out_data  = packing ? pk_out_data  : sp_out_data;

endmodule

// File: rtl/bus_width_adapter_chk.sv
module bus_width_adapter_chk
   import bwa_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input bwa_mode_e               mode,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [LANE_W*LANES-1:0] out_data
);

   localparam int WORD_W = LANE_W * LANES;

   // R11
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R10
   nine_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode == BWA_SPLIT4) |-> (out_data[WORD_W-1:LANE_W] == '0));

   // R10
   half_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode == BWA_SPLIT2) |-> (out_data[WORD_W-1:WORD_W/2] == '0));

   // R3
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(mode));

   // R8
   pack_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bwa_is_pack(mode) && $rose(out_valid)) |-> $past(in_valid && in_ready));

endmodule

bind bus_width_adapter bus_width_adapter_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode_q),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/bus_width_adapter_test.sv
module bus_width_adapter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_match = 1'b0, cfg_in_narrow = 1'b0, cfg_out_narrow = 1'b0, cfg_big_end = 1'b0;
   logic        in_valid = 1'b0, out_ready = 1'b0;
   logic [35:0] in_data = '0;
   logic        in_ready, out_valid;
   logic [35:0] out_data;

   always #5 clk = ~clk;

   bus_width_adapter uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_match(cfg_match), .cfg_in_narrow(cfg_in_narrow),
      .cfg_out_narrow(cfg_out_narrow), .cfg_big_end(cfg_big_end),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int unsigned n_checks = 0, n_fail = 0;
   bit          done = 1'b0;

   // reference model state
   int          m_n;
   bit          m_big, m_pack;
   logic [35:0] m_q[$];
   logic [35:0] m_acc;
   int          m_cnt;
   string       m_tag;
   logic [35:0] seen[$];
   logic [35:0] d_in[$];
   logic [35:0] d_exp[$];
   bit          prev_stall;
   logic [35:0] prev_data;

   task automatic check(input bit ok, input string tag, input logic [35:0] act,
                        input logic [35:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic configure(input bit bm, input bit iw, input bit ow, input bit be);
      cfg_match = bm; cfg_in_narrow = iw; cfg_out_narrow = ow; cfg_big_end = be;
      in_valid = 1'b0; out_ready = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 during reset
      check(out_valid == 1'b0, "R11 out_valid in reset", 36'(out_valid), 36'd0);
      check(in_ready == 1'b1, "R11 in_ready in reset", 36'(in_ready), 36'd1);
      rst_n = 1'b1;
      m_big = be;
      m_pack = bm && iw;
      m_n = !bm ? 1 : (ow ? 4 : 2);
      m_q.delete(); m_acc = '0; m_cnt = 0; prev_stall = 1'b0;
      if (!bm)         m_tag = "R1 R2";
      else if (m_pack) m_tag = be ? "R1 R6 R8 R10" : "R1 R7 R8 R10";
      else             m_tag = be ? "R1 R4 R10" : "R1 R5 R10";
      #1;
      // R11 after release
      check(out_valid == 1'b0, "R11 out_valid after reset", 36'(out_valid), 36'd0);
      check(in_ready == 1'b1, "R11 in_ready after reset", 36'(in_ready), 36'd1);
   endtask

   task automatic step(input bit iv, input logic [35:0] d, input bit ordy);
      bit fin, fout;
      bit exp_rdy;
      int w, s;
      logic [35:0] msk;
      @(negedge clk);
      in_valid = iv; in_data = d; out_ready = ordy;
      #1;
      if (m_pack) exp_rdy = (m_q.size() == 0) || ordy;
      else        exp_rdy = (m_q.size() == 0) || (m_q.size() == 1 && ordy);
      check(in_ready == exp_rdy, {"R12 in_ready ", m_tag}, 36'(in_ready), 36'(exp_rdy));
      check(out_valid == (m_q.size() > 0), {"R8 R12 out_valid ", m_tag},
            36'(out_valid), 36'(m_q.size() > 0));
      if (out_valid && m_q.size() > 0)
         check(out_data == m_q[0], {"R12 out_data ", m_tag}, out_data, m_q[0]);
      if (prev_stall)
         check(out_data == prev_data, "R9 stalled out_data", out_data, prev_data);
      fin  = in_valid && in_ready;
      fout = out_valid && out_ready;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (fout) seen.push_back(out_data);
      @(posedge clk);
      if (fout && m_q.size() > 0) void'(m_q.pop_front());
      if (fin) begin
         w   = 36 / m_n;
         msk = (36'd1 << w) - 36'd1;
         if (!m_pack) begin
            for (int k = 0; k < m_n; k++) begin
               s = m_big ? (m_n - 1 - k) : k;
               m_q.push_back((d >> (s * w)) & msk);
            end
         end else begin
            s = m_big ? (m_n - 1 - m_cnt) : m_cnt;
            m_acc = m_acc | ((d & msk) << (s * w));
            m_cnt++;
            if (m_cnt == m_n) begin
               m_q.push_back(m_acc);
               m_acc = '0;
               m_cnt = 0;
            end
         end
      end
   endtask

   task automatic directed(input bit bm, input bit iw, input bit ow, input bit be,
                           input string tag);
      configure(bm, iw, ow, be);
      seen.delete();
      foreach (d_in[i]) step(1'b1, d_in[i], 1'b1);
      repeat (6) step(1'b0, '0, 1'b1);
      check(seen.size() == d_exp.size(), {tag, " count"}, 36'(seen.size()), 36'(d_exp.size()));
      foreach (d_exp[i])
         if (i < seen.size()) check(seen[i] == d_exp[i], tag, seen[i], d_exp[i]);
   endtask

   initial begin
      // directed ordering
      d_in  = '{{9'h104, 9'h103, 9'h102, 9'h101}};
      d_exp = '{36'h104, 36'h103, 36'h102, 36'h101};
      directed(1, 0, 1, 1, "R4 split x9 big");
      d_exp = '{36'h101, 36'h102, 36'h103, 36'h104};
      directed(1, 0, 1, 0, "R5 split x9 little");
      d_in  = '{{18'h12345, 18'h0ABCD}};
      d_exp = '{36'h12345, 36'h0ABCD};
      directed(1, 0, 0, 1, "R4 split x18 big");
      d_exp = '{36'h0ABCD, 36'h12345};
      directed(1, 0, 0, 0, "R5 split x18 little");
      d_in  = '{36'hFFFFFF011, 36'hABCDE0022, 36'h123456033, 36'hFFFFFE044};
      d_exp = '{{9'h011, 9'h022, 9'h033, 9'h044}};
      directed(1, 1, 1, 1, "R6 R10 pack x9 big");
      d_exp = '{{9'h044, 9'h033, 9'h022, 9'h011}};
      directed(1, 1, 1, 0, "R7 R10 pack x9 little");
      d_in  = '{36'hF_C001_1111, 36'h3_0002_2222};
      d_exp = '{{18'h22222, 18'h11111}};
      directed(1, 1, 0, 0, "R7 R10 pack x18 little");
      d_in  = '{36'h9_8765_4321};
      d_exp = '{36'h9_8765_4321};
      directed(0, 1, 1, 1, "R2 unlisted code passes");

      // R8: a partial packed word stays hidden
      configure(1, 1, 1, 1);
      repeat (3) step(1'b1, 36'h1A5, 1'b1);
      repeat (4) step(1'b0, '0, 1'b1);
      check(out_valid == 1'b0, "R8 partial word hidden", 36'(out_valid), 36'd0);

      // randomized sweep over every pin code and endianness, pins scrambled after reset
      for (int code = 0; code < 8; code++) begin
         for (int be = 0; be < 2; be++) begin
            configure(code[2], code[1], code[0], be[0]);
            cfg_match = ~cfg_match; cfg_in_narrow = ~cfg_in_narrow;
            cfg_out_narrow = ~cfg_out_narrow; cfg_big_end = ~cfg_big_end;
            m_tag = {m_tag, " R3"};
            for (int c = 0; c < 400; c++) begin
               int pv, pr;
               pv = (c < 200) ? 70 : 40;
               pr = (c < 200) ? 40 : 85;
               step(($urandom % 100) < pv, {$urandom, $urandom} & 36'hF_FFFF_FFFF,
                    ($urandom % 100) < pr);
            end
            repeat (8) step(1'b0, '0, 1'b1);
            check(m_q.size() == 0 && out_valid == 1'b0, {"R12 drained ", m_tag},
                  36'(out_valid), 36'd0);
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule